// File: doc/BRIEF.md
# Element Width Cast Permuter

This block reinterprets one vector register value as a different element width. The register file keeps the value in an interleaved layout. The register is split into equal sections, and the elements of a given width are dealt across those sections round-robin. A byte therefore sits in a different register position for each element width. The block returns the register image that results from writing the value to memory at the old width and reading it back at the new width. Bytes end up in the same positions as in memory, and no sign or zero extension takes place.

The cast runs as a two-stage pipeline. The first stage gathers the register bytes into memory order according to the source width. The second stage deals those memory-ordered bytes back into register order according to the destination width. Both stages apply the same round-robin rule. When a section spans the whole register, both stages reduce to wiring and the cast becomes a copy. The block handles a single register at a time and accepts a new cast on every cycle.

Top module: `elw_cast_permuter`

## Requirements
- R1: While `rst_n` is low, `done_o` is 0 and `vec_o` is all zeros.
- R2: Width codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. For width W and S = VLEN/SLEN sections, bit w of element i sits at register bit (i mod S)·SLEN + (i div S)·W + w. The same bit sits at memory bit i·W + w. The result equals the source register mapped to memory order with the source width, then mapped back to register order with the destination width.
- R3: A cast from 8 to 16 bits forms each halfword i from memory bytes 2i (low half) and 2i+1 (high half). A cast from 8 to 64 bits of an input whose memory byte m holds m yields register byte r = r.
- R4: When the source and destination codes are equal, the result equals the input.
- R5: `done_o` is high for exactly one cycle, two clock edges after the edge that samples `start_i`. Starts on consecutive cycles each produce their own `done_o` pulse and result, in order.
- R6: `vec_o` keeps its value until the next result arrives. Changes on `vec_i`, `src_sew_i` and `dst_sew_i` without a start have no effect on it.
- R7: A cast from width A to width B, followed by a cast of that result from B back to A, restores the original value for all 16 width pairs.
- R8: When SLEN equals VLEN, every cast copies the input unchanged.
- R9: A cast from 64 to 32 bits splits each 64-bit memory element into two 32-bit elements. The lower-addressed half becomes the lower-numbered element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a cast using the inputs sampled this cycle |
| src_sew_i | input | 2 | Source element width code |
| dst_sew_i | input | 2 | Destination element width code |
| vec_i | input | VLEN | Register value in source-width layout |
| vec_o | output | VLEN | Register value in destination-width layout |
| done_o | output | 1 | One-cycle pulse when `vec_o` holds a new result |

## Verification
The bench builds two instances that share the same inputs. The first uses VLEN = 256 and SLEN = 64. Its four sections are wide enough for every element width, so every pair of unequal widths moves bytes across sections. The second uses VLEN = SLEN = 256, which exercises the copy case. Expected results come from a bit-level model of the memory round trip and from element-level ramp patterns, which makes the byte order inside concatenated and split elements visible.

// File: rtl/cast_pkg.sv
package cast_pkg;

  typedef enum logic [1:0] {
    SEW_E8  = 2'd0,
    SEW_E16 = 2'd1,
    SEW_E32 = 2'd2,
    SEW_E64 = 2'd3
  } sew_t;

  localparam int unsigned NUM_SEW = 4;

  function automatic int unsigned elem_bytes(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // memory byte m -> register byte holding it, for a width code
  function automatic int unsigned mem_to_reg(input int unsigned m,
                                             input int unsigned code,
                                             input int unsigned nsec,
                                             input int unsigned secb);
    int unsigned eb, idx, b;
    eb  = elem_bytes(code);
    idx = m / eb;
    b   = m % eb;
    return (idx % nsec) * secb + (idx / nsec) * eb + b;
  endfunction

  // register byte r -> memory byte it holds, for a width code
  function automatic int unsigned reg_to_mem(input int unsigned r,
                                             input int unsigned code,
                                             input int unsigned nsec,
                                             input int unsigned secb);
    int unsigned eb, sec, off, slot, b;
    eb   = elem_bytes(code);
    sec  = r / secb;
    off  = r % secb;
    slot = off / eb;
    b    = off % eb;
    return (slot * nsec + sec) * eb + b;
  endfunction

endpackage

// File: rtl/elw_byte_permute.sv
module elw_byte_permute #(
  parameter int unsigned NBYTES = 32,
  parameter int unsigned NSEC   = 4,
  parameter int unsigned SECB   = 8,
  parameter bit          GATHER = 1'b1
) (
  input  logic [NBYTES*8-1:0] din,
  input  logic [1:0]          sew,
  output logic [NBYTES*8-1:0] dout
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] cand [cast_pkg::NUM_SEW];
    for (genvar c = 0; c < cast_pkg::NUM_SEW; c++) begin : g_code
      if (GATHER) begin : g_gather
        localparam int unsigned FROM = cast_pkg::mem_to_reg(g, c, NSEC, SECB);
        assign cand[c] = din[FROM*8 +: 8];
      end else begin : g_scatter
        localparam int unsigned FROM = cast_pkg::reg_to_mem(g, c, NSEC, SECB);
        assign cand[c] = din[FROM*8 +: 8];
      end
    end
    assign dout[g*8 +: 8] = cand[sew];
  end

endmodule

// File: rtl/elw_pipe_ctrl.sv
module elw_pipe_ctrl #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [DEPTH-1:0] stage_vld_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_vld_o <= '0;
    end else begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        stage_vld_o[k] <= stage_vld_o[k-1];
      end
      stage_vld_o[0] <= start_i;
    end
  end

endmodule

// File: rtl/elw_cast_permuter.sv
module elw_cast_permuter #(
  parameter int unsigned VLEN = 256,
  parameter int unsigned SLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      src_sew_i,
  input  logic [1:0]      dst_sew_i,
  input  logic [VLEN-1:0] vec_i,
  output logic [VLEN-1:0] vec_o,
  output logic            done_o
);

  localparam int unsigned NBYTES = VLEN / 8;
  localparam int unsigned NSEC   = VLEN / SLEN;
  localparam int unsigned SECB   = SLEN / 8;
  localparam int unsigned STAGES = 2;

  cast_pkg::sew_t src_code, dst_code, dst_q;
  assign src_code = cast_pkg::sew_t'(src_sew_i);
  assign dst_code = cast_pkg::sew_t'(dst_sew_i);

  logic [STAGES-1:0] stage_vld;
  logic              mid_valid;
  logic [VLEN-1:0]   mem_img, mem_q, reg_img;

  elw_pipe_ctrl #(.DEPTH(STAGES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stage_vld_o (stage_vld)
  );

  assign mid_valid = stage_vld[0];
  assign done_o    = stage_vld[STAGES-1];

  // stage 1: register order at source width -> memory order
  elw_byte_permute #(.NBYTES(NBYTES), .NSEC(NSEC), .SECB(SECB), .GATHER(1'b1)) u_gather (
    .din  (vec_i),
    .sew  (src_code),
    .dout (mem_img)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      dst_q <= cast_pkg::SEW_E8;
    end else if (start_i) begin
      mem_q <= mem_img;
      dst_q <= dst_code;
    end
  end

  // stage 2: memory order -> register order at destination width
  elw_byte_permute #(.NBYTES(NBYTES), .NSEC(NSEC), .SECB(SECB), .GATHER(1'b0)) u_scatter (
    .din  (mem_q),
    .sew  (dst_q),
    .dout (reg_img)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o <= '0;
    end else if (mid_valid) begin
      vec_o <= reg_img;
    end
  end

  // ---------------- assertions ----------------
  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##2 done_o);

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i, 2));

  p_equal_sew_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ($past(src_sew_i, 2) == $past(dst_sew_i, 2))) |-> (vec_o == $past(vec_i, 2)));

  p_hold_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mid_valid |=> $stable(vec_o));

  if (NSEC == 1) begin : g_flat
    p_flat_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (vec_o == $past(vec_i, 2)));
  end

endmodule

// File: tb/test_elw_cast_permuter.sv
`timescale 1ns/1ps
module test_elw_cast_permuter;

  localparam int VLEN = 256;
  localparam int SLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] src_sew_i = 2'd0, dst_sew_i = 2'd0;
  logic [VLEN-1:0] vec_i = '0;
  logic [VLEN-1:0] vec_o, vec_o_flat;
  logic done_o, done_flat;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  elw_cast_permuter #(.VLEN(VLEN), .SLEN(SLEN)) i_elw_cast_permuter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sew_i(src_sew_i),
    .dst_sew_i(dst_sew_i), .vec_i(vec_i), .vec_o(vec_o), .done_o(done_o));

  elw_cast_permuter #(.VLEN(VLEN), .SLEN(VLEN)) i_elw_cast_permuter_flat (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sew_i(src_sew_i),
    .dst_sew_i(dst_sew_i), .vec_i(vec_i), .vec_o(vec_o_flat), .done_o(done_flat));

  // {src code, dst code, seed}
  localparam logic [7:0] VEC [16] = '{
    8'h01, 8'h12, 8'h23, 8'h34, 8'h65, 8'h76, 8'h47, 8'h98,
    8'hB9, 8'hCA, 8'hDB, 8'hEC, 8'h9D, 8'h2E, 8'h3F, 8'hE0};

  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] din,
                                            input int sc, input int dc, input int slen);
    logic [VLEN-1:0] mem, res;
    int nsec, sw, i, w;
    nsec = VLEN / slen;
    sw = 8 << sc;
    for (int p = 0; p < VLEN; p++) begin
      i = p / sw; w = p % sw;
      mem[p] = din[(i % nsec) * slen + (i / nsec) * sw + w];
    end
    sw = 8 << dc;
    for (int p = 0; p < VLEN; p++) begin
      i = p / sw; w = p % sw;
      res[(i % nsec) * slen + (i / nsec) * sw + w] = mem[p];
    end
    return res;
  endfunction

  function automatic logic [VLEN-1:0] mix(input int seed);
    logic [31:0] x;
    logic [VLEN-1:0] v;
    x = 32'h9e3779b9 ^ seed;
    for (int k = 0; k < VLEN / 32; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      v[k*32 +: 32] = x ^ (x >> 13);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cast(input logic [VLEN-1:0] d, input int s, input int t,
                         output logic [VLEN-1:0] r, output logic [VLEN-1:0] rf);
    @(negedge clk);
    vec_i = d; src_sew_i = 2'(s); dst_sew_i = 2'(t); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R5 done early", VLEN'(done_o), '0);
    @(negedge clk);
    chk(done_o == 1'b1 && done_flat == 1'b1, "R5 done pulse", VLEN'(done_o), VLEN'(1));
    r = vec_o; rf = vec_o_flat;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] r, rf, r2, rf2, ramp8, a, b, exp;
    // R1: reset state with activity on inputs
    vec_i = mix(7); start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && vec_o == '0, "R1 reset state", vec_o, '0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 idle after reset", VLEN'(done_o), '0);

    // R2 + R8: table of width pairs against the model
    for (int n = 0; n < 16; n++) begin
      a = mix(int'(VEC[n][3:0]) + 100 * n);
      do_cast(a, int'(VEC[n][7:6]), int'(VEC[n][5:4]), r, rf);
      exp = model(a, int'(VEC[n][7:6]), int'(VEC[n][5:4]), SLEN);
      chk(r == exp, "R2 cast matches memory round trip", r, exp);
      chk(rf == a, "R8 full-width section copies", rf, a);
    end

    // R3: 8-bit ramp in register layout, memory byte m holds m
    for (int m = 0; m < VLEN / 8; m++)
      ramp8[((m % 4) * 8 + m / 4) * 8 +: 8] = 8'(m);
    do_cast(ramp8, 0, 1, r, rf);
    for (int i = 0; i < VLEN / 16; i++) begin
      exp = VLEN'({8'(2 * i + 1), 8'(2 * i)});
      chk(r[(i % 4) * SLEN + (i / 4) * 16 +: 16] == exp[15:0], "R3 halfword concatenation",
          VLEN'(r[(i % 4) * SLEN + (i / 4) * 16 +: 16]), exp);
    end
    do_cast(ramp8, 0, 3, r, rf);
    for (int k = 0; k < VLEN / 8; k++) exp[k*8 +: 8] = 8'(k);
    chk(r == exp, "R3 bytes to 64-bit in memory order", r, exp);

    // R9: 64 -> 32 split of the memory ramp
    do_cast(exp, 3, 2, r, rf);
    for (int i = 0; i < VLEN / 32; i++) begin
      b = VLEN'({8'(4 * i + 3), 8'(4 * i + 2), 8'(4 * i + 1), 8'(4 * i)});
      chk(r[(i % 4) * SLEN + (i / 4) * 32 +: 32] == b[31:0], "R9 narrowing split",
          VLEN'(r[(i % 4) * SLEN + (i / 4) * 32 +: 32]), b);
    end

    // R4: equal widths copy
    for (int c = 0; c < 4; c++) begin
      a = mix(500 + c);
      do_cast(a, c, c, r, rf);
      chk(r == a, "R4 equal width copy", r, a);
    end

    // R7: round trip for all pairs
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        a = mix(900 + 4 * s + t);
        do_cast(a, s, t, r, rf);
        do_cast(r, t, s, r2, rf2);
        chk(r2 == a, "R7 round trip restores", r2, a);
      end
    end

    // R5: back-to-back starts
    a = mix(31); b = mix(32);
    @(negedge clk);
    vec_i = a; src_sew_i = 2'd0; dst_sew_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    vec_i = b; src_sew_i = 2'd3; dst_sew_i = 2'd1;
    @(negedge clk);
    start_i = 1'b0;
    exp = model(a, 0, 2, SLEN);
    chk(done_o == 1'b1 && vec_o == exp, "R5 first of back-to-back", vec_o, exp);
    @(negedge clk);
    exp = model(b, 3, 1, SLEN);
    chk(done_o == 1'b1 && vec_o == exp, "R5 second of back-to-back", vec_o, exp);

    // R6: input changes without start leave output alone
    for (int k = 0; k < 5; k++) begin
      vec_i = mix(700 + k); src_sew_i = 2'(k); dst_sew_i = 2'(3 - (k % 4));
      @(negedge clk);
      chk(done_o == 1'b0 && vec_o == exp, "R6 output holds without start", vec_o, exp);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule